// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an asynchronous static memory of 256K words by 16 bits. The host presents one request at a time on a valid/ready handshake: an 18-bit word address, a write flag, 16 bits of write data and a two-bit lane mask. The controller then drives the memory's address, its two chip selects (one active low, one active high), output enable, write enable and the two byte enables. It shares the 16-bit data bus with the memory through per-lane tristate drivers.

Every phase length is set from nanosecond minimums and a clock-period parameter. Each count is the ceiling of the time divided by the period, and never less than one cycle. Between requests the memory is kept in standby. On a write, the bus is driven only inside the write-enable low window, and only after a turnaround gap that lets the memory release the bus. On a read, the output enable is held low for the full access time. The lanes are then sampled, and the result goes back to the host with any masked-off byte forced to zero.

Top module: `sramc_top`

## Requirements
- R1: After reset the host sees ready high and rsp_valid low, and the memory sees chip select 1 high, chip select 2 low, write enable high and output enable high.
- R2: A write stores only the lanes whose mask bit is set. Mask bit 0 selects data bits 7:0 (lower byte enable), and mask bit 1 selects bits 15:8 (upper byte enable). A later read of that address returns the stored bytes.
- R3: Write enable stays low for exactly WE_CYC cycles per write. WE_CYC is the largest of ceil(pulse width), ceil(address-to-end) and ceil(write-enable-to-high-Z) + ceil(data setup). This is 2 cycles at 20 ns with the default times.
- R4: The controller drives a data lane only while write enable is low, and never in the first cycle after write enable falls.
- R5: Output enable is high for the whole time write enable is low, so the two are never low together.
- R6: For a read, output enable is low for RD_CYC = max(ceil(cycle), ceil(address access), ceil(output-enable access)) cycles (3 at defaults). rsp_valid is high for exactly one cycle, starting at the RD_CYC-th rising edge after the accepting edge.
- R7: On a read, lanes whose mask bit is clear are returned as zero on rsp_rdata.
- R8: Ready falls at the accepting edge. It stays low for WE_CYC + max(1, ceil(write cycle) - WE_CYC) cycles on a write (3 at defaults) and RD_CYC + ceil(output-enable-to-high-Z) cycles on a read (4 at defaults).
- R9: Whenever ready is high, chip select 1 is high and chip select 2 is low, which places the memory in standby.
- R10: While chip select 1 is held low, the address does not change.
- R11: A write with mask 00 keeps both byte enables high, and no byte of the memory changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_cs1_n | output | 1 | Chip select 1, active low |
| mem_cs2 | output | 1 | Chip select 2, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq | inout | 16 | Shared data bus |

## Verification
The bench runs directed partial-lane writes and reads at the top and bottom addresses, plus a mask-00 write. Where the controller mishandles lanes, these show up as a clobbered neighbouring byte or as non-zero data on a masked lane. A memory model in the bench latches data only when a write ends. If data is driven too late or released too early, the model stores the wrong value, and the read-back that follows fails. The bench also measures the write-enable pulse width, the busy time and the position of the read strobe. This catches phase counts that round down or drop a cycle, and also catches a recovery phase that is skipped.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_REC  = 2'd3
    } phase_e;

    // ceiling of ns / clk_ns, never below one cycle
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int AW        = 18,
    parameter int LANES     = 2,
    parameter int CLK_NS    = 20,
    parameter int T_WC_NS   = 45,
    parameter int T_PWE_NS  = 35,
    parameter int T_AW_NS   = 35,
    parameter int T_SD_NS   = 20,
    parameter int T_HZWE_NS = 20,
    parameter int T_RC_NS   = 45,
    parameter int T_AA_NS   = 45,
    parameter int T_DOE_NS  = 20,
    parameter int T_HZOE_NS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [LANES-1:0] req_mask,
    output logic             req_ready,
    output logic             accept_wr,
    output logic             capture,
    output logic             rsp_valid,
    output logic [AW-1:0]    mem_addr,
    output logic             cs_on,
    output logic             oe_on,
    output logic             we_on,
    output logic [LANES-1:0] be_on,
    output logic             drive
);

    localparam int TA_CYC   = ns2cyc(T_HZWE_NS, CLK_NS);
    localparam int SD_CYC   = ns2cyc(T_SD_NS, CLK_NS);
    localparam int WE_CYC   = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                   TA_CYC + SD_CYC);
    localparam int WREC_CYC = imax(1, ns2cyc(T_WC_NS, CLK_NS) - WE_CYC);
    localparam int RD_CYC   = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                   ns2cyc(T_DOE_NS, CLK_NS));
    localparam int RREC_CYC = ns2cyc(T_HZOE_NS, CLK_NS);
    localparam int MAXC     = imax(imax(WE_CYC, WREC_CYC), imax(RD_CYC, RREC_CYC));
    localparam int CW       = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CW-1:0]    cnt;
        logic [AW-1:0]    addr;
        logic             cs;
        logic             oe;
        logic             we;
        logic [LANES-1:0] be;
        logic             drv;
        logic             rv;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        capture   = 1'b0;
        accept_wr = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.addr = req_addr;
                    st_d.cs   = 1'b1;
                    st_d.be   = req_mask;
                    if (req_write) begin
                        accept_wr = 1'b1;
                        st_d.ph   = PH_WR;
                        st_d.we   = 1'b1;
                        st_d.cnt  = CW'(WE_CYC - 1);
                    end else begin
                        st_d.ph   = PH_RD;
                        st_d.oe   = 1'b1;
                        st_d.cnt  = CW'(RD_CYC - 1);
                    end
                end
            end
            PH_WR: begin
                if (st_q.cnt == '0) begin
                    st_d.ph  = PH_REC;
                    st_d.cnt = CW'(WREC_CYC - 1);
                    st_d.we  = 1'b0;
                    st_d.cs  = 1'b0;
                    st_d.be  = '0;
                    st_d.drv = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    // cycles of write enable low elapsed after this edge
                    st_d.drv = (CW'(WE_CYC - 1) - st_d.cnt) >= CW'(TA_CYC);
                end
            end
            PH_RD: begin
                if (st_q.cnt == '0) begin
                    capture  = 1'b1;
                    st_d.rv  = 1'b1;
                    st_d.ph  = PH_REC;
                    st_d.cnt = CW'(RREC_CYC - 1);
                    st_d.oe  = 1'b0;
                    st_d.cs  = 1'b0;
                    st_d.be  = '0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_REC: begin
                if (st_q.cnt == '0) st_d.ph = PH_IDLE;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, addr: '0, cs: 1'b0, oe: 1'b0,
                      we: 1'b0, be: '0, drv: 1'b0, rv: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.ph == PH_IDLE);
    assign rsp_valid = st_q.rv;
    assign mem_addr  = st_q.addr;
    assign cs_on     = st_q.cs;
    assign oe_on     = st_q.oe;
    assign we_on     = st_q.we;
    assign be_on     = st_q.be;
    assign drive     = st_q.drv;

endmodule

// File: rtl/sramc_lane.sv
module sramc_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] wbyte,
    input  logic       drive,
    input  logic       lane_on,
    input  logic       capture,
    input  logic [7:0] dq_in,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic [7:0] rbyte
);

    typedef struct packed {
        logic [7:0] wdat;
        logic [7:0] rdat;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (load)    ln_d.wdat = wbyte;
        if (capture) ln_d.rdat = lane_on ? dq_in : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign dq_out = ln_q.wdat;
    assign dq_oe  = drive && lane_on;
    assign rbyte  = ln_q.rdat;

endmodule

// File: rtl/sramc_top.sv
module sramc_top #(
    parameter int AW        = 18,
    parameter int DW        = 16,
    parameter int CLK_NS    = 20,
    parameter int T_WC_NS   = 45,
    parameter int T_PWE_NS  = 35,
    parameter int T_AW_NS   = 35,
    parameter int T_SD_NS   = 20,
    parameter int T_HZWE_NS = 20,
    parameter int T_RC_NS   = 45,
    parameter int T_AA_NS   = 45,
    parameter int T_DOE_NS  = 20,
    parameter int T_HZOE_NS = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs1_n,
    output logic          mem_cs2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    inout  wire  [DW-1:0] mem_dq
);

    localparam int LANES = DW / 8;

    logic             accept_wr, capture, cs_on, oe_on, we_on, drive;
    logic [LANES-1:0] be_on, lane_oe;

    sramc_seq #(
        .AW(AW), .LANES(LANES), .CLK_NS(CLK_NS),
        .T_WC_NS(T_WC_NS), .T_PWE_NS(T_PWE_NS), .T_AW_NS(T_AW_NS),
        .T_SD_NS(T_SD_NS), .T_HZWE_NS(T_HZWE_NS), .T_RC_NS(T_RC_NS),
        .T_AA_NS(T_AA_NS), .T_DOE_NS(T_DOE_NS), .T_HZOE_NS(T_HZOE_NS)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_mask(req_mask[LANES-1:0]),
        .req_ready(req_ready), .accept_wr(accept_wr), .capture(capture),
        .rsp_valid(rsp_valid), .mem_addr(mem_addr),
        .cs_on(cs_on), .oe_on(oe_on), .we_on(we_on),
        .be_on(be_on), .drive(drive)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] dq_out;
        sramc_lane lane_i (
            .clk(clk), .rst_n(rst_n),
            .load(accept_wr), .wbyte(req_wdata[g*8 +: 8]),
            .drive(drive), .lane_on(be_on[g]), .capture(capture),
            .dq_in(mem_dq[g*8 +: 8]), .dq_out(dq_out),
            .dq_oe(lane_oe[g]), .rbyte(rsp_rdata[g*8 +: 8])
        );
        assign mem_dq[g*8 +: 8] = lane_oe[g] ? dq_out : 8'hzz;
    end

    assign mem_cs1_n = ~cs_on;
    assign mem_cs2   = cs_on;
    assign mem_oe_n  = ~oe_on;
    assign mem_we_n  = ~we_on;
    assign mem_lb_n  = ~be_on[0];
    assign mem_ub_n  = ~be_on[LANES-1];

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
    parameter int AW    = 18,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [1:0]       req_mask,
    input logic             rsp_valid,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_cs1_n,
    input logic             mem_cs2,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic             mem_ub_n,
    input logic             mem_lb_n,
    input logic [LANES-1:0] lane_oe
);

    p_idle_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && !mem_cs2));

    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_drive_in_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe != '0) |-> !mem_we_n);

    p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (lane_oe == '0));

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_nomask_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_mask == 2'b00) |=> (mem_ub_n && mem_lb_n));

endmodule

bind sramc_top sramc_chk #(.AW(AW), .LANES(LANES)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mask(req_mask), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .lane_oe(lane_oe)
);

// File: tb/sramc_top_tb_top.sv
`timescale 1ns/1ps
module sramc_top_tb_top;

    localparam int AW = 18;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    wire  [DW-1:0] mem_dq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sramc_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n), .mem_dq(mem_dq)
    );

    // expected phase lengths, from the requirements
    function automatic int cyc(input int ns);
        int c;
        c = (ns + 19) / 20;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int WE_EXP  = mx(mx(cyc(35), cyc(35)), cyc(20) + cyc(20));
    localparam int WR_BUSY = WE_EXP + mx(1, cyc(45) - WE_EXP);
    localparam int RD_EXP  = mx(mx(cyc(45), cyc(45)), cyc(20));
    localparam int RD_BUSY = RD_EXP + cyc(20);

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mdl_mem [logic [AW-1:0]];
    logic [15:0] mdl_word;
    logic        rd_act, wr_act, was_wr;
    logic [15:0] pend;
    logic [1:0]  pend_v;

    always_comb begin
        if (mdl_mem.exists(mem_addr)) mdl_word = mdl_mem[mem_addr];
        else                          mdl_word = 16'h0000;
    end
    assign rd_act = !mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n;
    assign wr_act = !mem_cs1_n && mem_cs2 && !mem_we_n;
    assign mem_dq[7:0]  = (rd_act && !mem_lb_n) ? mdl_word[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (rd_act && !mem_ub_n) ? mdl_word[15:8] : 8'hzz;

    logic [AW-1:0] wr_addr;
    int we_low = 0;

    initial begin
        was_wr = 1'b0; pend = '0; pend_v = '0; wr_addr = '0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_act) begin
                wr_addr = mem_addr;
                if (!mem_lb_n) begin pend[7:0]  = mem_dq[7:0];  pend_v[0] = 1'b1; end
                if (!mem_ub_n) begin pend[15:8] = mem_dq[15:8]; pend_v[1] = 1'b1; end
                // R5: output enable must stay high under write enable low
                chk("R5 oe_n during write", 32'(mem_oe_n), 32'd1);
            end else if (was_wr) begin
                if (pend_v != 2'b00) begin
                    if (!mdl_mem.exists(wr_addr)) mdl_mem[wr_addr] = 16'h0000;
                    if (pend_v[0]) mdl_mem[wr_addr][7:0]  = pend[7:0];
                    if (pend_v[1]) mdl_mem[wr_addr][15:8] = pend[15:8];
                end
                pend_v = 2'b00;
            end
            was_wr = wr_act;
            // R3: write enable low width
            if (!mem_we_n) we_low++;
            else if (we_low != 0) begin
                chk("R3 we_n low cycles", 32'(we_low), 32'(WE_EXP));
                we_low = 0;
            end
        end
    end

    // ---------------- reference memory ----------------
    logic [15:0] exp_mem [logic [AW-1:0]];

    task automatic do_op(input logic wr, input logic [AW-1:0] a,
                         input logic [15:0] wd, input logic [1:0] m);
        int busy, idx, rv_at;
        logic [15:0] rd, ex;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        chk("R9 standby while ready", 32'(mem_cs1_n && !mem_cs2), 32'd1);
        req_write = wr; req_addr = a; req_wdata = wd; req_mask = m; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; idx = 1; rv_at = 0; rd = '0;
        while (!req_ready) begin
            if (rsp_valid) begin rv_at = idx; rd = rsp_rdata; end
            busy++; idx++;
            @(negedge clk);
        end
        if (wr) begin
            chk("R8 write busy cycles", 32'(busy), 32'(WR_BUSY));
            if (!exp_mem.exists(a)) exp_mem[a] = 16'h0000;
            if (m[0]) exp_mem[a][7:0]  = wd[7:0];
            if (m[1]) exp_mem[a][15:8] = wd[15:8];
        end else begin
            chk("R8 read busy cycles", 32'(busy), 32'(RD_BUSY));
            chk("R6 rsp_valid position", 32'(rv_at), 32'(RD_EXP + 1));
            ex = exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
            if (m[0]) chk("R2 R4 R10 low lane data", 32'(rd[7:0]), 32'(ex[7:0]));
            else      chk("R7 masked low lane zero", 32'(rd[7:0]), 32'd0);
            if (m[1]) chk("R2 R4 R10 high lane data", 32'(rd[15:8]), 32'(ex[15:8]));
            else      chk("R7 masked high lane zero", 32'(rd[15:8]), 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [AW-1:0] pool [10];
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 cs/we/oe", {28'd0, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 32'hB);
        rst_n = 1'b1;

        // directed corners
        do_op(1'b1, 18'h3FFFF, 16'hA55A, 2'b11);
        do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        do_op(1'b1, 18'h00000, 16'h1234, 2'b11);
        do_op(1'b1, 18'h00000, 16'hBEEF, 2'b01);   // only low byte
        do_op(1'b0, 18'h00000, 16'h0000, 2'b11);   // expect 12EF
        do_op(1'b1, 18'h00000, 16'hC0DE, 2'b10);   // only high byte
        do_op(1'b0, 18'h00000, 16'h0000, 2'b11);   // expect C0EF
        do_op(1'b1, 18'h3FFFF, 16'hFFFF, 2'b00);   // R11: nothing stored
        do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b11);   // R11: still A55A
        do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b01);   // R7 upper zero
        do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b10);   // R7 lower zero
        do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b00);   // R7 both zero

        // constrained random over a small address pool
        pool[0] = 18'h00000; pool[1] = 18'h3FFFF;
        for (int i = 2; i < 10; i++) pool[i] = 18'($urandom());
        for (int i = 0; i < 300; i++) begin
            do_op(1'($urandom()), pool[$urandom_range(0, 9)],
                  16'($urandom()), 2'($urandom()));
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule